// File: doc/BRIEF.md
# Half-bridge gate enable gating

This block is the clocked control path of a two-channel half-bridge gate driver. It takes the already-synchronized high-side and low-side command inputs plus three synchronized status flags: logic-supply undervoltage, floating-supply undervoltage and a negative switch-node excursion. From them it produces one registered enable level for each output stage. The analog comparators, level shifting and output buffers sit outside it.

Each enable follows its command in phase with one clock of latency, and the block has no cross-conduction interlock. A logic-supply undervoltage blanks both channels. A floating-supply undervoltage blanks only the high side, and the high side then waits for a fresh rising edge on its command before it turns on again. A negative excursion that lasts longer than a qualification window forces the high side off for a fixed hold window. Both windows are given in nanoseconds and turned into cycle counts from a clock-frequency parameter, rounded up.

Top module: `hb_gate_ctrl`

## Requirements
- R1: With no fault flag active, `lo_en_o` equals `lin_i` and `ho_en_o` equals `hin_i` (once armed) one clock after sampling. Both enables may be 1 together.
- R2: A sampled `vcc_uv_i` = 1 drives both enables to 0 on the next clock. This holds for as long as the flag stays set, including a flag that never clears.
- R3: When `vcc_uv_i` returns to 0, both enables follow their commands again on the next clock, and no new command edge is needed.
- R4: A sampled `vbs_uv_i` = 1 drives `ho_en_o` to 0 on the next clock and leaves `lo_en_o` following `lin_i`.
- R5: Once `vbs_uv_i` has been 1, `ho_en_o` stays 0 until `hin_i` is sampled 0 and then 1 with `vbs_uv_i` = 0. A `hin_i` that is already high at recovery does not count. A rising edge sampled in the same cycle that the flag clears does count.
- R6: `nvs_i` qualifies only after it has been sampled 1 on QUAL_CYC+1 consecutive clocks, where QUAL_CYC = ceil(QUAL_NS x CLK_FREQ_HZ / 1e9) (10 at the defaults). A shorter excursion has no effect.
- R7: A qualifying sample forces `ho_en_o` to 0 for exactly HOLD_CYC = ceil(HOLD_NS x CLK_FREQ_HZ / 1e9) output cycles (900 at the defaults), starting at the next clock. After that window the high side follows `hin_i` again. `lo_en_o` is not affected. A continuously high `nvs_i` qualifies only once.
- R8: A new qualifying excursion during a hold restarts the full HOLD_CYC window from its own qualifying sample.
- R9: Synchronous `rst_i` = 1 drives both enables to 0. After reset the high side needs a new `hin_i` rising edge, exactly as after a floating-supply undervoltage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| hin_i | input | 1 | High-side command, synchronized |
| lin_i | input | 1 | Low-side command, synchronized |
| vcc_uv_i | input | 1 | Logic-supply undervoltage flag, 1 = under |
| vbs_uv_i | input | 1 | Floating-supply undervoltage flag, 1 = under |
| nvs_i | input | 1 | Negative switch-node excursion flag, 1 = below limit |
| ho_en_o | output | 1 | High-side stage enable, registered |
| lo_en_o | output | 1 | Low-side stage enable, registered |

## Verification
The bench aims at the re-arm corners. It covers a command held high through floating-supply recovery, a rising edge that lands in the very cycle of recovery, and a command held high across reset. A design that re-armed on level rather than on edge would turn the high side on in the first case, and one that ignored the same-cycle edge would leave it dark in the second. It measures the hold window to the exact cycle, both after a single event and after a retrigger, and it sends an excursion one sample short of qualifying. An off-by-one counter would show up as a window one cycle long or short, or as a false trip. It also checks that a logic-supply undervoltage blanks and then releases both channels without needing an edge, and that the low side stays live through every high-side-only fault.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

  // Convert a duration in ns to whole clock cycles, rounding up.
  function automatic int unsigned ns_to_cycles(input int unsigned freq_hz,
                                               input int unsigned dur_ns);
    longint unsigned prod;
    prod = longint'(freq_hz) * longint'(dur_ns) + 64'd999_999_999;
    return int'(prod / 64'd1_000_000_000);
  endfunction

  // High-side permission for the next output cycle.
  function automatic logic ho_permit(input logic hin, input logic armed,
                                     input logic rise, input logic vcc_uv,
                                     input logic vbs_uv, input logic nvs_block);
    return hin & (armed | rise) & ~vcc_uv & ~vbs_uv & ~nvs_block;
  endfunction

  // Low-side permission for the next output cycle.
  function automatic logic lo_permit(input logic lin, input logic vcc_uv);
    return lin & ~vcc_uv;
  endfunction

endpackage

// File: rtl/hb_edge_arm.sv
module hb_edge_arm (
  input  logic clk_i,
  input  logic rst_i,
  input  logic hin_i,
  input  logic vbs_uv_i,
  output logic hin_rise_o,
  output logic armed_o
);
  logic hin_prev;
  logic armed_q;

  assign hin_rise_o = hin_i & ~hin_prev;
  assign armed_o    = armed_q;

  // Previous value resets high so a command held high through reset is no edge.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hin_prev <= 1'b1;
      armed_q  <= 1'b0;
    end else begin
      hin_prev <= hin_i;
      if (vbs_uv_i)
        armed_q <= 1'b0;
      else if (hin_rise_o)
        armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/hb_nvs_guard.sv
module hb_nvs_guard #(
  parameter int unsigned QUAL_CYC = 10,
  parameter int unsigned HOLD_CYC = 900
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic nvs_i,
  output logic fire_o,
  output logic block_o
);
  localparam int unsigned QSAT = QUAL_CYC + 1;
  localparam int unsigned QW   = $clog2(QSAT + 1);
  localparam int unsigned HW   = $clog2(HOLD_CYC + 1);
  localparam logic [QW-1:0] QUAL_HIT  = QW'(QUAL_CYC);
  localparam logic [QW-1:0] QUAL_TOP  = QW'(QSAT);
  localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_CYC - 1);

  logic [QW-1:0] run_cnt;
  logic [HW-1:0] hold_cnt;
  logic          hold_live;

  // Fires on the sample after QUAL_CYC earlier consecutive high samples.
  assign fire_o    = nvs_i && (run_cnt == QUAL_HIT);
  assign hold_live = (hold_cnt != '0);
  assign block_o   = fire_o | hold_live;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_cnt <= '0;
    end else if (!nvs_i) begin
      run_cnt <= '0;
    end else if (run_cnt != QUAL_TOP) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  generate
    if (HOLD_CYC > 1) begin : g_hold_counter
      always_ff @(posedge clk_i) begin
        if (rst_i)
          hold_cnt <= '0;
        else if (fire_o)
          hold_cnt <= HOLD_LOAD;
        else if (hold_live)
          hold_cnt <= hold_cnt - 1'b1;
      end
    end else begin : g_hold_single
      always_ff @(posedge clk_i) begin
        hold_cnt <= '0;
      end
    end
  endgenerate
endmodule

// File: rtl/hb_out_stage.sv
module hb_out_stage
  import hb_gate_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic hin_i,
  input  logic lin_i,
  input  logic vcc_uv_i,
  input  logic vbs_uv_i,
  input  logic armed_i,
  input  logic rise_i,
  input  logic block_i,
  output logic ho_en_o,
  output logic lo_en_o
);
  logic ho_next;
  logic lo_next;

  always_comb begin
    ho_next = ho_permit(hin_i, armed_i, rise_i, vcc_uv_i, vbs_uv_i, block_i);
    lo_next = lo_permit(lin_i, vcc_uv_i);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ho_en_o <= 1'b0;
      lo_en_o <= 1'b0;
    end else begin
      ho_en_o <= ho_next;
      lo_en_o <= lo_next;
    end
  end
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_gate_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 200_000_000,
  parameter int unsigned QUAL_NS     = 50,
  parameter int unsigned HOLD_NS     = 4500
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic hin_i,
  input  logic lin_i,
  input  logic vcc_uv_i,
  input  logic vbs_uv_i,
  input  logic nvs_i,
  output logic ho_en_o,
  output logic lo_en_o
);
  localparam int unsigned QUAL_CYC = ns_to_cycles(CLK_FREQ_HZ, QUAL_NS);
  localparam int unsigned HOLD_CYC = ns_to_cycles(CLK_FREQ_HZ, HOLD_NS);

  // Named internal events, visible to the bound checker.
  logic hin_rise;
  logic ho_armed;
  logic nvs_fire;
  logic nvs_block;

  hb_edge_arm u_arm (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .hin_i      (hin_i),
    .vbs_uv_i   (vbs_uv_i),
    .hin_rise_o (hin_rise),
    .armed_o    (ho_armed)
  );

  hb_nvs_guard #(
    .QUAL_CYC (QUAL_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) u_nvs (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .nvs_i   (nvs_i),
    .fire_o  (nvs_fire),
    .block_o (nvs_block)
  );

  hb_out_stage u_out (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .hin_i    (hin_i),
    .lin_i    (lin_i),
    .vcc_uv_i (vcc_uv_i),
    .vbs_uv_i (vbs_uv_i),
    .armed_i  (ho_armed),
    .rise_i   (hin_rise),
    .block_i  (nvs_block),
    .ho_en_o  (ho_en_o),
    .lo_en_o  (lo_en_o)
  );
endmodule

// File: rtl/hb_gate_ctrl_chk.sv
module hb_gate_ctrl_chk (
  input logic clk_i,
  input logic rst_i,
  input logic hin_i,
  input logic lin_i,
  input logic vcc_uv_i,
  input logic vbs_uv_i,
  input logic hin_rise,
  input logic ho_armed,
  input logic nvs_fire,
  input logic ho_en_o,
  input logic lo_en_o
);
  AST_HO_NEEDS_CMD: assert property (@(posedge clk_i) disable iff (rst_i)
    ho_en_o |-> $past(hin_i)); // R1
  AST_VCC_UV_BLANKS: assert property (@(posedge clk_i) disable iff (rst_i)
    vcc_uv_i |=> (!ho_en_o && !lo_en_o)); // R2
  AST_LO_TRACKS: assert property (@(posedge clk_i) disable iff (rst_i)
    !vcc_uv_i |=> (lo_en_o == $past(lin_i))); // R3
  AST_VBS_UV_HO_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
    vbs_uv_i |=> !ho_en_o); // R4
  AST_NO_LEVEL_REARM: assert property (@(posedge clk_i) disable iff (rst_i)
    (!ho_armed && !hin_rise) |=> !ho_en_o); // R5
  AST_NVS_TRIP: assert property (@(posedge clk_i) disable iff (rst_i)
    nvs_fire |=> !ho_en_o); // R7
  AST_RESET_LOW: assert property (@(posedge clk_i)
    rst_i |=> (!ho_en_o && !lo_en_o)); // R9
endmodule

bind hb_gate_ctrl hb_gate_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .hin_i    (hin_i),
  .lin_i    (lin_i),
  .vcc_uv_i (vcc_uv_i),
  .vbs_uv_i (vbs_uv_i),
  .hin_rise (hin_rise),
  .ho_armed (ho_armed),
  .nvs_fire (nvs_fire),
  .ho_en_o  (ho_en_o),
  .lo_en_o  (lo_en_o)
);

// File: tb/hb_gate_ctrl_bench.sv
module hb_gate_ctrl_bench;
  // Window lengths restated for 200 MHz: 5 ns per cycle.
  localparam int QUAL_T = (50 + 4) / 5;    // 10
  localparam int HOLD_T = (4500 + 4) / 5;  // 900

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hin = 1'b0, lin = 1'b0, vcc = 1'b0, vbs = 1'b0, nvs = 1'b0;
  logic ho, lo;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hb_gate_ctrl u_hb_gate_ctrl (
    .clk_i(clk), .rst_i(rst), .hin_i(hin), .lin_i(lin),
    .vcc_uv_i(vcc), .vbs_uv_i(vbs), .nvs_i(nvs),
    .ho_en_o(ho), .lo_en_o(lo)
  );

  // {req[3:0], hin, lin, vcc_uv, vbs_uv, nvs, exp_ho, exp_lo}
  localparam int NV = 18;
  localparam logic [10:0] VEC [NV] = '{
    {4'd9, 5'b10000, 2'b00},  // R9 hin high since reset: no edge
    {4'd1, 5'b01000, 2'b01},  // R1
    {4'd1, 5'b10000, 2'b10},  // R1 rising edge arms
    {4'd1, 5'b11000, 2'b11},  // R1 both on, no interlock
    {4'd1, 5'b00000, 2'b00},  // R1
    {4'd2, 5'b11100, 2'b00},  // R2 logic-supply UV blanks both
    {4'd3, 5'b11000, 2'b11},  // R3 resume with no edge
    {4'd4, 5'b11010, 2'b01},  // R4 high side only
    {4'd5, 5'b11000, 2'b01},  // R5 held-high hin does not re-arm
    {4'd5, 5'b00000, 2'b00},  // R5
    {4'd5, 5'b10000, 2'b10},  // R5 fresh edge re-arms
    {4'd4, 5'b10010, 2'b00},  // R4
    {4'd4, 5'b01010, 2'b01},  // R4 low side live
    {4'd5, 5'b11000, 2'b11},  // R5 edge in recovery cycle counts
    {4'd2, 5'b11110, 2'b00},  // R2 both flags
    {4'd5, 5'b11000, 2'b01},  // R5 disarmed by prior UV
    {4'd5, 5'b00000, 2'b00},  // R5
    {4'd5, 5'b10000, 2'b10}   // R5
  };

  task automatic drive(input logic h, input logic l, input logic v,
                       input logic b, input logic n);
    @(negedge clk);
    hin = h; lin = l; vcc = v; vbs = b; nvs = n;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Drive n consecutive high excursion samples with hin and lin high.
  task automatic nvs_pulse(input int n);
    for (int k = 0; k < n; k++) drive(1, 1, 0, 0, 1);
  endtask

  // Count low ho samples, current one included, until ho returns.
  task automatic measure_low(output int cnt);
    cnt = (ho == 1'b0) ? 1 : 0;
    while (ho == 1'b0 && cnt < 5000) begin
      drive(1, 1, 0, 0, 0);
      if (ho == 1'b0) cnt++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int low_cnt;
    // R9 reset with both commands high
    hin = 1; lin = 1;
    repeat (4) @(posedge clk);
    #1;
    check("R9", "ho in reset", ho, 0);
    check("R9", "lo in reset", lo, 0);
    @(negedge clk); rst = 0;

    for (int i = 0; i < NV; i++) begin
      string tag;
      drive(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      tag = $sformatf("R%0d row%0d", VEC[i][10:7], i);
      check(tag, "ho", ho, VEC[i][1]);
      check(tag, "lo", lo, VEC[i][0]);
    end

    // R6: excursion exactly QUAL_T samples long has no effect
    drive(1, 1, 0, 0, 0);
    for (int k = 0; k < QUAL_T; k++) begin
      drive(1, 1, 0, 0, 1);
      check("R6", "ho during short excursion", ho, 1);
    end
    drive(1, 1, 0, 0, 0);
    check("R6", "ho after short excursion", ho, 1);

    // R7: QUAL_T+1 samples trip, hold exactly HOLD_T
    nvs_pulse(QUAL_T);
    check("R7", "ho before qualifying sample", ho, 1);
    nvs_pulse(1);
    check("R7", "ho on trip", ho, 0);
    check("R7", "lo on trip", lo, 1);
    measure_low(low_cnt);
    check("R7", "hold length", low_cnt, HOLD_T);
    check("R7", "ho after hold", ho, 1);

    // R7: sustained excursion trips only once
    nvs_pulse(QUAL_T + 1 + HOLD_T + 5);
    check("R7", "ho after hold with flag still high", ho, 1);
    drive(1, 1, 0, 0, 0);

    // R8: retrigger during hold restarts the window
    nvs_pulse(QUAL_T + 1);
    check("R8", "first trip", ho, 0);
    for (int k = 0; k < 200; k++) drive(1, 1, 0, 0, 0);
    check("R8", "still held", ho, 0);
    nvs_pulse(QUAL_T + 1);
    measure_low(low_cnt);
    check("R8", "hold length from second trip", low_cnt, HOLD_T);

    // R2: logic-supply UV held with toggling commands
    for (int k = 0; k < 20; k++) begin
      drive(k[0], ~k[0], 1, 0, 0);
      check("R2", "ho under UV", ho, 0);
      check("R2", "lo under UV", lo, 0);
    end
    drive(1, 1, 0, 0, 0);
    check("R3", "ho after UV clear", ho, 1);

    // R9: reset again, hin held high across release
    @(negedge clk); rst = 1;
    @(posedge clk); #1;
    check("R9", "ho in second reset", ho, 0);
    @(negedge clk); rst = 0;
    drive(1, 1, 0, 0, 0);
    check("R9", "ho after reset without edge", ho, 0);
    check("R9", "lo after reset", lo, 1);
    drive(0, 1, 0, 0, 0);
    drive(1, 1, 0, 0, 0);
    check("R9", "ho after fresh edge", ho, 1);

    done = 1'b1;
    finish_run();
  end
endmodule